// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block judges whether a buffer of 64-bit words, captured from a random source running in its diagnostic mode, follows the expected Galois-style polynomial sequence. After a start pulse it walks the buffer through a synchronous read port. It compares every word except slot zero against a single expected value and adds the hits to a running total. After each full scan it decides: pass if the total has reached the goal, fail if the scan budget is spent, otherwise advance the expected value one polynomial step and scan again.

The seed of the sequence is picked at start between two constants, one per source generation. The buffer itself is filled elsewhere. This block only reads it, one word per clock with one cycle of read latency, and reports through a one-cycle completion pulse and a held verdict.

Top module: `lfsr_seq_checker`

## Requirements
- R1: While reset is asserted, and after it is released with no start, busy, done, pass and rd_en are all 0.
- R2: The expected value begins at the selected seed. Each advance shifts it left by one bit and, when the bit leaving position 63 was 1, XORs the polynomial POLY into the result.
- R3: Each scan asserts rd_en for exactly DEPTH-1 consecutive cycles, presenting rd_addr 1, 2, ... DEPTH-1 in that order. Address 0 is never read, so a matching word in slot 0 never counts.
- R4: Hits from all scans add into one running total that is cleared only when a start is accepted.
- R5: When the running total is at least GOAL at the end of a scan, the run ends with pass = 1. Hits above GOAL within that scan do no harm.
- R6: When LOOP_MAX scans have completed without the total reaching GOAL, the run ends with pass = 0.
- R7: seed_sel is sampled with the accepted start: 0 selects SEED_A and 1 selects SEED_B.
- R8: A run that ends after k scans raises done exactly k*(DEPTH+1) clock edges after the edge that accepted start. done stays high for one cycle, and busy is 1 from the edge after the accepted start until done rises.
- R9: pass keeps its verdict after done until the next accepted start, which clears it to 0.
- R10: A start pulse while busy is ignored: the verdict and the done timing are those of the run already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check when idle |
| seed_sel | input | 1 | Seed choice sampled at start: 0 = SEED_A, 1 = SEED_B |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | ADDR_W | Buffer word index |
| rd_data | input | WORD_W | Buffer word, valid the cycle after rd_en |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse at the end of a check |
| pass | output | 1 | Verdict of the last check, held until the next start |

## Verification
A corrupted expected value or a wrong polynomial step only shows at the ports through the verdict and through the scan count hidden in the done latency. A single wrong step turns a buffer that matches at a later scan into a fail, or shifts the pass to a different scan, and this becomes visible at most LOOP_MAX*(DEPTH+1) edges after start. A running total that is dropped between scans, or one that counts slot 0, moves done by whole multiples of DEPTH+1 cycles. That makes the latency as telling as the pass bit. An address sequencing fault shows within the first DEPTH-1 cycles on rd_addr and rd_en.

// File: rtl/lfsr_seq_pkg.sv
package lfsr_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_EVAL  = 2'd3
    } chk_state_e;

endpackage

// File: rtl/lfsr_adv_step.sv
module lfsr_adv_step #(
    parameter int              WORD_W = 64,
    parameter logic [WORD_W-1:0] POLY = '0
) (
    input  logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] nxt
);
    // One Galois step: shift left, fold the polynomial in when the top bit leaves.
    assign nxt[0] = POLY[0] & cur[WORD_W-1];
    for (genvar i = 1; i < WORD_W; i++) begin : g_bit
        assign nxt[i] = cur[i-1] ^ (POLY[i] & cur[WORD_W-1]);
    end
endmodule

// File: rtl/seq_word_cmp.sv
module seq_word_cmp #(
    parameter int WORD_W = 64
) (
    input  logic              vld,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] expv,
    output logic              hit
);
    assign hit = vld && (word == expv);
endmodule

// File: rtl/lfsr_seq_checker.sv
module lfsr_seq_checker #(
    parameter int                WORD_W   = 64,
    parameter int                DEPTH    = 8,
    parameter int                GOAL     = 3,
    parameter int                LOOP_MAX = 6,
    parameter logic [WORD_W-1:0] POLY     = 64'h231D_CEE9_1262_B8A3,
    parameter logic [WORD_W-1:0] SEED_A   = 64'hC3A5_1E0F_9B72_4D68,
    parameter logic [WORD_W-1:0] SEED_B   = 64'h5E17_A0C9_3F84_B26D,
    localparam int               ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seed_sel,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    import lfsr_seq_pkg::*;

    localparam int CNT_W  = $clog2(GOAL + DEPTH + 1);
    localparam int ITER_W = $clog2(LOOP_MAX + 1);
    localparam logic [CNT_W-1:0]  GOAL_C = CNT_W'(GOAL);
    localparam logic [ITER_W-1:0] LOOP_C = ITER_W'(LOOP_MAX);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(1);

    typedef struct packed {
        chk_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] expv;
        logic [CNT_W-1:0]  total;
        logic [ITER_W-1:0] iter;
        logic              cmp_vld;
        logic              done;
        logic              pass;
    } chk_regs_t;

    chk_regs_t q, d;

    logic [WORD_W-1:0] exp_adv;
    logic              hit;
    logic [ITER_W-1:0] iter_inc;

    lfsr_adv_step #(
        .WORD_W (WORD_W),
        .POLY   (POLY)
    ) u_adv (
        .cur (q.expv),
        .nxt (exp_adv)
    );

    seq_word_cmp #(
        .WORD_W (WORD_W)
    ) u_cmp (
        .vld  (q.cmp_vld),
        .word (rd_data),
        .expv (q.expv),
        .hit  (hit)
    );

    assign iter_inc = q.iter + ITER_W'(1);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.cmp_vld = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_SCAN;
                    d.addr  = FIRST_A;
                    d.expv  = seed_sel ? SEED_B : SEED_A;
                    d.total = '0;
                    d.iter  = '0;
                    d.pass  = 1'b0;
                end
            end
            ST_SCAN: begin
                d.cmp_vld = 1'b1;
                d.addr    = q.addr + ADDR_W'(1);
                if (q.addr == LAST_A) begin
                    d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                d.state = ST_EVAL;
            end
            ST_EVAL: begin
                if (q.total >= GOAL_C) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.pass  = 1'b1;
                end else if (iter_inc == LOOP_C) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.pass  = 1'b0;
                end else begin
                    d.state = ST_SCAN;
                    d.iter  = iter_inc;
                    d.expv  = exp_adv;
                    d.addr  = FIRST_A;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (hit) begin
            d.total = q.total + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.addr    <= '0;
            q.expv    <= '0;
            q.total   <= '0;
            q.iter    <= '0;
            q.cmp_vld <= 1'b0;
            q.done    <= 1'b0;
            q.pass    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_en   = (q.state == ST_SCAN);
    assign rd_addr = q.addr;
    assign busy    = (q.state != ST_IDLE);
    assign done    = q.done;
    assign pass    = q.pass;

endmodule

// File: rtl/lfsr_seq_checker_sva.sv
module lfsr_seq_checker_sva #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              done,
    input logic              pass
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !rd_en);

    a_r3_no_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_addr != '0);

    a_r3_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> rd_addr == ADDR_W'($past(rd_addr) + ADDR_W'(1)));

    a_r9_pass_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || $stable(pass)));

    a_r9_pass_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pass);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !busy && !done && !pass && !rd_en);
endmodule

bind lfsr_seq_checker lfsr_seq_checker_sva #(
    .ADDR_W (ADDR_W)
) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .busy    (busy),
    .done    (done),
    .pass    (pass)
);

// File: tb/lfsr_seq_checker_tb_top.sv
module lfsr_seq_checker_tb_top;
    localparam int          W     = 64;
    localparam int          D     = 8;
    localparam int          GOAL  = 3;
    localparam int          LOOPS = 6;
    localparam int          AW    = $clog2(D);
    localparam logic [63:0] POLY  = 64'h231D_CEE9_1262_B8A3;
    localparam logic [63:0] SA    = 64'hC3A5_1E0F_9B72_4D68;
    localparam logic [63:0] SB    = 64'h5E17_A0C9_3F84_B26D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          seed_sel = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [W-1:0]  rd_data;
    logic          busy, done, pass;
    logic [W-1:0]  mem [D];

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    lfsr_seq_checker #(
        .WORD_W (W), .DEPTH (D), .GOAL (GOAL), .LOOP_MAX (LOOPS),
        .POLY (POLY), .SEED_A (SA), .SEED_B (SB)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .seed_sel (seed_sel),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .busy (busy), .done (done), .pass (pass)
    );

    function automatic logic [63:0] adv(input logic [63:0] v);
        return v[63] ? ((v << 1) ^ POLY) : (v << 1);
    endfunction

    function automatic logic [63:0] seq(input logic [63:0] seed, input int s);
        logic [63:0] v = seed;
        for (int i = 0; i < s; i++) v = adv(v);
        return v;
    endfunction

    // Spec model: returns number of scans; ok set to the verdict.
    function automatic int model(input logic [63:0] seed, output bit ok);
        logic [63:0] e = seed;
        int tot = 0;
        for (int it = 0; it < LOOPS; it++) begin
            for (int i = 1; i < D; i++) if (mem[i] == e) tot++;
            if (tot >= GOAL) begin ok = 1'b1; return it + 1; end
            e = adv(e);
        end
        ok = 1'b0;
        return LOOPS;
    endfunction

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_noise();
        for (int i = 0; i < D; i++) mem[i] = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(i) * 64'h0101_0101_0101_0101);
    endtask

    task automatic run(input bit sel, input string req, input bit poke_busy);
        bit ok;
        int scans, n, lat;
        bit addr_ok = 1'b1;
        scans = model(sel ? SB : SA, ok);
        lat = scans * (D + 1) + 1;
        @(negedge clk);
        seed_sel = sel;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        seed_sel = ~sel;
        n = 1;
        chk(busy && !pass, "R9", "cleared and busy after start", {busy, pass}, 2);
        while (!done && n < 2000) begin
            if (n < D) begin
                if (!(rd_en && rd_addr == AW'(n))) addr_ok = 1'b0;
            end
            if (poke_busy && n == 4) start = 1'b1;
            if (poke_busy && n == 5) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(addr_ok, "R3", "first scan addresses 1..D-1", addr_ok, 1);
        chk(n == lat, poke_busy ? "R10" : "R8", "done latency", n, lat);
        chk(pass == ok, req, "verdict", pass, ok);
        @(negedge clk);
        chk(!done, "R8", "done width", done, 0);
        repeat (3) @(negedge clk);
        chk(pass == ok && !busy, "R9", "verdict held", pass, ok);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        fill_noise();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !rd_en, "R1", "outputs in reset", {busy, done, pass, rd_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !rd_en, "R1", "idle after reset", {busy, done, pass, rd_en}, 0);

        // R2/R5/R6 sweep: the sequence word placed at every step index up to the budget.
        for (int s = 0; s <= LOOPS; s++) begin
            fill_noise();
            for (int i = 1; i <= GOAL; i++) mem[i] = seq(SA, s);
            run(1'b0, (s < LOOPS) ? "R2 R5" : "R6", 1'b0);
        end

        // R4: hits spread over scans 0, 1 and 3.
        fill_noise();
        mem[2] = seq(SA, 0); mem[4] = seq(SA, 1); mem[6] = seq(SA, 3);
        run(1'b0, "R4", 1'b0);

        // R3: slot 0 holds a hit that must not count.
        fill_noise();
        mem[0] = SA; mem[1] = SA; mem[2] = SA;
        run(1'b0, "R3", 1'b0);

        // R7: second seed, then same buffer with the first seed.
        fill_noise();
        for (int i = 5; i < D; i++) mem[i] = seq(SB, 2);
        run(1'b1, "R7", 1'b0);
        run(1'b0, "R7", 1'b0);

        // R5: more hits than the goal in one scan.
        fill_noise();
        for (int i = 1; i < D; i++) mem[i] = SA;
        run(1'b0, "R5", 1'b0);

        // R10: start pulse while busy.
        fill_noise();
        for (int i = 1; i <= GOAL; i++) mem[i] = seq(SA, 2);
        run(1'b0, "R10", 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule